// File: doc/BRIEF.md
# Two-Level Board Power Throttle Controller

This block turns a stream of board power samples into throttle requests for a processor. Each time a sample strobe arrives, it adds the readings of three supply rails into one total. It then compares that total against two thresholds. The lower threshold guards against a sustained mild overload. The upper threshold guards against a heavy one.

Each threshold trips only after the total has stayed strictly above it for an unbroken run of millisecond ticks, and each one needs its own margin of drop before it lets go. When the lower level trips, the block asks for one frequency step down. When the upper level trips, it forces minimum frequency, and a core-voltage reduction follows after a fixed further delay. Both thresholds normally follow the rated power (TDP) input. A host may overwrite either threshold while the block runs.

Top module: `pwr_throttle_ctrl`

## Requirements
- R1: On a `smp_vld` strobe the total power is `rail_a + rail_b + rail_c`, computed at full width with no truncation. That total is the only quantity compared against the thresholds.
- R2: `mild_req` rises on the 300th `ms_tick` of an unbroken stretch in which the latest total is strictly greater than the low threshold. A total equal to the threshold never starts the count.
- R3: `freq_req` is 2'b00 when neither level is active, 2'b01 (one step down) when only the low level is active, and 2'b10 (minimum frequency) when the high level is active.
- R4: With TDP of 250 W or less, an active low level stays active while the total is above `low threshold - 15`. It clears on the first sample at or below that value.
- R5: `severe_req` rises on the 50th `ms_tick` of an unbroken stretch in which the total is strictly greater than the high threshold.
- R6: An active high level stays active until a sample is at or below `high threshold - 40`.
- R7: While `severe_req` is high, `freq_req` reads 2'b10 whatever the low level's state. The low level keeps tracking its own timer and hysteresis underneath.
- R8: `vdrop_req` rises on the 350th `ms_tick` counted while `severe_req` is high.
- R9: `vdrop_req` falls in the same cycle as `severe_req`. A later assertion of `severe_req` restarts the 350-tick delay from zero.
- R10: Any sample at or below a threshold clears that level's persistence count. The full run of ticks is then needed again.
- R11: The default thresholds are `TDP*105/100` (low) and `TDP*125/100` (high), computed in integer arithmetic. They are loaded at reset and reloaded whenever `tdp_w` changes value.
- R12: A write on `pl1_wr` or `pl0_wr` replaces the low or high threshold with the write data. The value holds until the next reset or change of `tdp_w`.
- R13: With TDP above 250 W, the low level's release margin is 20 W instead of 15 W.
- R14: After reset, `mild_req`, `severe_req` and `vdrop_req` are 0, `freq_req` is 2'b00, and both persistence counts are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Rail readings are valid this cycle |
| rail_a | input | RAIL_W | Power of first supply rail, watts |
| rail_b | input | RAIL_W | Power of second supply rail, watts |
| rail_c | input | RAIL_W | Power of third supply rail, watts |
| tdp_w | input | RAIL_W | Rated power, watts |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pl1_wr | input | 1 | Host write of the low threshold |
| pl1_wdata | input | RAIL_W+2 | Low threshold value, watts |
| pl0_wr | input | 1 | Host write of the high threshold |
| pl0_wdata | input | RAIL_W+2 | High threshold value, watts |
| mild_req | output | 1 | Low level active |
| severe_req | output | 1 | High level active |
| freq_req | output | 2 | Frequency request code (see R3) |
| vdrop_req | output | 1 | Core-voltage reduction request |

## Verification
The hardest state to reach is the one where both levels are active and the voltage request is high. From there, a total can be chosen that releases the high level but not the low one.

The stimulus first raises the total above both thresholds. It holds that total long enough for the high level to trip at tick 50 and for the low level to trip underneath it at tick 300. It keeps holding until the 350-tick voltage delay has expired. It then lowers the total to exactly 40 W below the high threshold. At that point `freq_req` must drop from minimum to one step down, and `vdrop_req` must clear in the same cycle.

Ticks are issued in bursts of exact length, so each trip point is checked one tick before it and on the tick itself.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        FRQ_NOMINAL = 2'b00,
        FRQ_STEP    = 2'b01,
        FRQ_MIN     = 2'b10
    } freq_lvl_e;

    localparam int unsigned NUM_LEVELS = 2;
    localparam int unsigned LVL_LOW    = 0;
    localparam int unsigned LVL_HIGH   = 1;

    // Integer percentage of a base value, truncated.
    function automatic int unsigned scale_pct(input int unsigned base, input int unsigned pct);
        return (base * pct) / 100;
    endfunction

endpackage

// File: rtl/pt_sum.sv
module pt_sum #(
    parameter int RAIL_W = 10,
    localparam int TOT_W = RAIL_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [RAIL_W-1:0] rail_a,
    input  logic [RAIL_W-1:0] rail_b,
    input  logic [RAIL_W-1:0] rail_c,
    output logic              total_vld,
    output logic [TOT_W-1:0]  total_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            total_vld <= 1'b0;
            total_q   <= '0;
        end else begin
            total_vld <= smp_vld;
            if (smp_vld)
                total_q <= TOT_W'(rail_a) + TOT_W'(rail_b) + TOT_W'(rail_c);
        end
    end

endmodule

// File: rtl/pt_level.sv
module pt_level #(
    parameter int W    = 12,
    parameter int HOLD = 300,
    localparam int CW  = $clog2(HOLD + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld,
    input  logic [W-1:0] total,
    input  logic [W-1:0] thr,
    input  logic [W-1:0] margin,
    input  logic         tick,
    output logic         act
);

    logic          above;
    logic [CW-1:0] cnt;
    logic          over, at_or_below, released;

    assign over        = total > thr;
    assign at_or_below = vld && !over;
    // Release test is done one bit wider so thr - margin never wraps.
    assign released    = ({1'b0, total} + {1'b0, margin}) <= {1'b0, thr};

    always_ff @(posedge clk) begin
        if (rst) begin
            above <= 1'b0;
            cnt   <= '0;
            act   <= 1'b0;
        end else begin
            if (vld) begin
                above <= over;
                if (!over)
                    cnt <= '0;
                if (act && released)
                    act <= 1'b0;
            end
            if (tick && above && !act && !at_or_below) begin
                if (cnt == CW'(HOLD - 1)) begin
                    act <= 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pt_vdelay.sv
module pt_vdelay #(
    parameter int DLY = 350,
    localparam int CW = $clog2(DLY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic severe,
    input  logic tick,
    output logic vdrop
);

    logic [CW-1:0] cnt;
    logic          done;

    always_ff @(posedge clk) begin
        if (rst || !severe) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (tick && !done) begin
            if (cnt == CW'(DLY - 1)) begin
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Gated with severe so the request drops in the same cycle severe does.
    assign vdrop = done && severe;

endmodule

// File: rtl/pwr_throttle_ctrl.sv
module pwr_throttle_ctrl
    import pt_pkg::*;
#(
    parameter int RAIL_W        = 10,
    parameter int LOW_PCT       = 105,
    parameter int HIGH_PCT      = 125,
    parameter int HOLD_LOW_MS   = 300,
    parameter int HOLD_HIGH_MS  = 50,
    parameter int VDROP_MS      = 350,
    parameter int TDP_SPLIT_W   = 250,
    parameter int MARGIN_LOW_S  = 15,
    parameter int MARGIN_LOW_L  = 20,
    parameter int MARGIN_HIGH   = 40,
    localparam int TOT_W        = RAIL_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [RAIL_W-1:0] rail_a,
    input  logic [RAIL_W-1:0] rail_b,
    input  logic [RAIL_W-1:0] rail_c,
    input  logic [RAIL_W-1:0] tdp_w,
    input  logic              ms_tick,
    input  logic              pl1_wr,
    input  logic [TOT_W-1:0]  pl1_wdata,
    input  logic              pl0_wr,
    input  logic [TOT_W-1:0]  pl0_wdata,
    output logic              mild_req,
    output logic              severe_req,
    output logic [1:0]        freq_req,
    output logic              vdrop_req
);

    logic              total_vld;
    logic [TOT_W-1:0]  total_q;
    logic [RAIL_W-1:0] tdp_q;
    logic [TOT_W-1:0]  thr      [NUM_LEVELS];
    logic [TOT_W-1:0]  margin   [NUM_LEVELS];
    logic [TOT_W-1:0]  def_thr  [NUM_LEVELS];
    logic              lvl_act  [NUM_LEVELS];
    logic [TOT_W-1:0]  thr_high;
    freq_lvl_e         freq_lvl;

    pt_sum #(.RAIL_W(RAIL_W)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .rail_a    (rail_a),
        .rail_b    (rail_b),
        .rail_c    (rail_c),
        .total_vld (total_vld),
        .total_q   (total_q)
    );

    assign def_thr[LVL_LOW]  = TOT_W'(scale_pct(32'(tdp_w), LOW_PCT));
    assign def_thr[LVL_HIGH] = TOT_W'(scale_pct(32'(tdp_w), HIGH_PCT));

    always_ff @(posedge clk) begin
        if (rst) begin
            tdp_q         <= tdp_w;
            thr[LVL_LOW]  <= def_thr[LVL_LOW];
            thr[LVL_HIGH] <= def_thr[LVL_HIGH];
        end else begin
            if (tdp_w != tdp_q) begin
                tdp_q         <= tdp_w;
                thr[LVL_LOW]  <= def_thr[LVL_LOW];
                thr[LVL_HIGH] <= def_thr[LVL_HIGH];
            end
            if (pl1_wr)
                thr[LVL_LOW] <= pl1_wdata;
            if (pl0_wr)
                thr[LVL_HIGH] <= pl0_wdata;
        end
    end

    assign margin[LVL_LOW]  = (int'(tdp_q) <= TDP_SPLIT_W) ? TOT_W'(MARGIN_LOW_S)
                                                           : TOT_W'(MARGIN_LOW_L);
    assign margin[LVL_HIGH] = TOT_W'(MARGIN_HIGH);
    assign thr_high         = thr[LVL_HIGH];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        pt_level #(
            .W    (TOT_W),
            .HOLD ((g == LVL_LOW) ? HOLD_LOW_MS : HOLD_HIGH_MS)
        ) u_level (
            .clk    (clk),
            .rst    (rst),
            .vld    (total_vld),
            .total  (total_q),
            .thr    (thr[g]),
            .margin (margin[g]),
            .tick   (ms_tick),
            .act    (lvl_act[g])
        );
    end

    assign mild_req   = lvl_act[LVL_LOW];
    assign severe_req = lvl_act[LVL_HIGH];

    always_comb begin
        if (severe_req)    freq_lvl = FRQ_MIN;
        else if (mild_req) freq_lvl = FRQ_STEP;
        else               freq_lvl = FRQ_NOMINAL;
    end
    assign freq_req = freq_lvl;

    pt_vdelay #(.DLY(VDROP_MS)) u_vdelay (
        .clk    (clk),
        .rst    (rst),
        .severe (severe_req),
        .tick   (ms_tick),
        .vdrop  (vdrop_req)
    );

endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
    parameter int TOT_W       = 12,
    parameter int MARGIN_HIGH = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             ms_tick,
    input logic             total_vld,
    input logic [TOT_W-1:0] total_q,
    input logic [TOT_W-1:0] thr_high,
    input logic             mild_req,
    input logic             severe_req,
    input logic [1:0]       freq_req,
    input logic             vdrop_req
);

    p_min_priority_r7: assert property (@(posedge clk) disable iff (rst)
        severe_req |-> freq_req == 2'b10);

    p_freq_code_r3: assert property (@(posedge clk) disable iff (rst)
        (!severe_req && mild_req) |-> freq_req == 2'b01);

    p_nominal_r3: assert property (@(posedge clk) disable iff (rst)
        (freq_req == 2'b00) |-> (!mild_req && !severe_req));

    p_vdrop_follows_r9: assert property (@(posedge clk) disable iff (rst)
        vdrop_req |-> severe_req);

    p_mild_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(mild_req) && !$past(rst)) |-> $past(ms_tick));

    p_severe_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(severe_req) && !$past(rst)) |-> $past(ms_tick));

    p_vdrop_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(vdrop_req) && !$past(rst)) |-> ($past(ms_tick) && $past(severe_req)));

    p_severe_release_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(severe_req) && !$past(rst)) |->
            ($past(total_vld) &&
             ({1'b0, $past(total_q)} + (TOT_W+1)'(MARGIN_HIGH) <= {1'b0, $past(thr_high)})));

endmodule

bind pwr_throttle_ctrl pt_checker #(.TOT_W(TOT_W), .MARGIN_HIGH(MARGIN_HIGH)) u_pt_checker (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .total_vld  (total_vld),
    .total_q    (total_q),
    .thr_high   (thr_high),
    .mild_req   (mild_req),
    .severe_req (severe_req),
    .freq_req   (freq_req),
    .vdrop_req  (vdrop_req)
);

// File: tb/test_pwr_throttle_ctrl.sv
module test_pwr_throttle_ctrl;

    localparam int RAIL_W = 10;
    localparam int TOT_W  = RAIL_W + 2;

    typedef struct packed {
        logic [RAIL_W-1:0] ra;
        logic [RAIL_W-1:0] rb;
        logic [RAIL_W-1:0] rc;
        logic [15:0]       nticks;
        logic [1:0]        freq;
        logic              mild;
        logic              sev;
        logic              vd;
    } vec_t;

    localparam int NVEC = 13;
    // TDP = 200 W: low threshold 210, high threshold 250, low margin 15.
    localparam vec_t VEC [NVEC] = '{
        '{10'd70, 10'd70, 10'd70, 16'd400, 2'b00, 1'b0, 1'b0, 1'b0}, // 0: R1 R2 total 210 equals threshold
        '{10'd70, 10'd70, 10'd71, 16'd299, 2'b00, 1'b0, 1'b0, 1'b0}, // 1: R2 one tick short
        '{10'd70, 10'd70, 10'd71, 16'd1,   2'b01, 1'b1, 1'b0, 1'b0}, // 2: R2 R3 trips on tick 300
        '{10'd65, 10'd65, 10'd70, 16'd10,  2'b01, 1'b1, 1'b0, 1'b0}, // 3: R4 200 held by hysteresis
        '{10'd65, 10'd65, 10'd65, 16'd0,   2'b00, 1'b0, 1'b0, 1'b0}, // 4: R4 195 releases
        '{10'd84, 10'd84, 10'd83, 16'd49,  2'b00, 1'b0, 1'b0, 1'b0}, // 5: R5 one tick short
        '{10'd84, 10'd84, 10'd83, 16'd1,   2'b10, 1'b0, 1'b1, 1'b0}, // 6: R5 trips on tick 50
        '{10'd84, 10'd84, 10'd83, 16'd250, 2'b10, 1'b1, 1'b1, 1'b0}, // 7: R7 low active underneath
        '{10'd84, 10'd84, 10'd83, 16'd99,  2'b10, 1'b1, 1'b1, 1'b0}, // 8: R8 tick 349
        '{10'd84, 10'd84, 10'd83, 16'd1,   2'b10, 1'b1, 1'b1, 1'b1}, // 9: R8 tick 350
        '{10'd70, 10'd70, 10'd71, 16'd0,   2'b10, 1'b1, 1'b1, 1'b1}, // 10: R6 211 still held
        '{10'd70, 10'd70, 10'd70, 16'd0,   2'b01, 1'b1, 1'b0, 1'b0}, // 11: R6 R9 210 releases high
        '{10'd40, 10'd30, 10'd30, 16'd0,   2'b00, 1'b0, 1'b0, 1'b0}  // 12: R4 100 releases low
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2:  return "R2";
            3, 4, 12: return "R4";
            5, 6:     return "R5";
            7:        return "R7";
            8, 9:     return "R8";
            10:       return "R6";
            default:  return "R9";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_vld = 1'b0;
    logic [RAIL_W-1:0] rail_a = '0, rail_b = '0, rail_c = '0;
    logic [RAIL_W-1:0] tdp_w = 10'd200;
    logic              ms_tick = 1'b0;
    logic              pl1_wr = 1'b0, pl0_wr = 1'b0;
    logic [TOT_W-1:0]  pl1_wdata = '0, pl0_wdata = '0;
    logic              mild_req, severe_req, vdrop_req;
    logic [1:0]        freq_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_throttle_ctrl i_pwr_throttle_ctrl (
        .clk, .rst, .smp_vld, .rail_a, .rail_b, .rail_c, .tdp_w, .ms_tick,
        .pl1_wr, .pl1_wdata, .pl0_wr, .pl0_wdata,
        .mild_req, .severe_req, .freq_req, .vdrop_req
    );

    task automatic chk(input string req, input logic [1:0] ef, input logic em,
                       input logic es, input logic ev);
        logic [4:0] act, exp;
        act = {freq_req, mild_req, severe_req, vdrop_req};
        exp = {ef, em, es, ev};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {freq,mild,severe,vdrop} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic sample(input int a, input int b, input int c);
        @(negedge clk);
        rail_a = RAIL_W'(a); rail_b = RAIL_W'(b); rail_c = RAIL_W'(c);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            ms_tick = 1'b1;
            repeat (n) @(negedge clk);
            ms_tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R14 reset state", 2'b00, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            sample(int'(VEC[i].ra), int'(VEC[i].rb), int'(VEC[i].rc));
            ticks(int'(VEC[i].nticks));
            chk($sformatf("%s vector %0d", vec_req(i), i),
                VEC[i].freq, VEC[i].mild, VEC[i].sev, VEC[i].vd);
        end

        // R10: a sample at or below the low threshold restarts the count.
        sample(70, 70, 71);
        ticks(200);
        sample(70, 70, 65);
        sample(70, 70, 71);
        ticks(299);
        chk("R10 count restarted", 2'b00, 1'b0, 1'b0, 1'b0);
        ticks(1);
        chk("R10 full run trips", 2'b01, 1'b1, 1'b0, 1'b0);
        sample(40, 30, 30);
        chk("R10 release", 2'b00, 1'b0, 1'b0, 1'b0);

        // R12: host override of low threshold to 150.
        @(negedge clk);
        pl1_wdata = 12'd150; pl1_wr = 1'b1;
        @(negedge clk);
        pl1_wr = 1'b0;
        sample(60, 50, 50);
        ticks(300);
        chk("R12 low override 150", 2'b01, 1'b1, 1'b0, 1'b0);

        // R11 R13: TDP 300 reloads 315 / 375, low margin becomes 20.
        @(negedge clk);
        tdp_w = 10'd300;
        repeat (2) @(negedge clk);
        sample(100, 100, 96);
        chk("R13 296 held with 20 W margin", 2'b01, 1'b1, 1'b0, 1'b0);
        sample(100, 100, 95);
        chk("R11 R13 295 releases at 315-20", 2'b00, 1'b0, 1'b0, 1'b0);

        // R12: host override of high threshold to 300.
        @(negedge clk);
        pl0_wdata = 12'd300; pl0_wr = 1'b1;
        @(negedge clk);
        pl0_wr = 1'b0;
        sample(101, 100, 100);
        ticks(49);
        chk("R12 high override tick 49", 2'b00, 1'b0, 1'b0, 1'b0);
        ticks(1);
        chk("R12 high override tick 50", 2'b10, 1'b0, 1'b1, 1'b0);

        // R14: reset mid-run clears everything and restores defaults (375).
        do_reset();
        chk("R14 reset while severe", 2'b00, 1'b0, 1'b0, 1'b0);
        sample(101, 100, 100);
        ticks(60);
        chk("R12 R14 override gone after reset", 2'b00, 1'b0, 1'b0, 1'b0);

        // R9: restart of the voltage delay after a new severe episode.
        sample(130, 130, 130);
        ticks(50);
        ticks(349);
        sample(50, 50, 50);
        chk("R9 release before delay", 2'b00, 1'b0, 1'b0, 1'b0);
        sample(130, 130, 130);
        ticks(50);
        ticks(349);
        chk("R9 delay restarted tick 349", 2'b10, 1'b1, 1'b1, 1'b0);
        ticks(1);
        chk("R8 delay tick 350", 2'b10, 1'b1, 1'b1, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule